// File: doc/BRIEF.md
# Dual 32-bit Interval Timer

This peripheral holds two independent 32-bit up-counters, a low half and a high half, behind a small word-wide register port. Each half has a counter, a period and a 2-bit run mode. The run mode selects stopped, single-shot or repeating operation. Both run modes share one control word. A global control word selects the counting arrangement and releases each half from reset. Each half drives its own interrupt line. The line pulses for one cycle when the counter reaches the period.

The low half can also carry a compare register. A parameter enables it and another parameter sets its offset. The low-half interrupt then also pulses when the running count equals the compare value. This lets one free-running counter serve both as a time base and as an event source.

Software normally sets a period and clears the counter. It selects a run mode for each half, then releases the halves through the global control word. It reads the counters at any time. Read data is registered and appears one cycle after the address is presented.

Top module: `dual_timer32`

## Requirements
- R1: After reset, both counters read 0, both periods read 0xFFFFFFFF, the run-mode and global control words read 0, the compare register reads 0xFFFFFFFF, and both interrupts are low.
- R2: Registers sit at byte offsets 0x10 (low count), 0x14 (high count), 0x18 (low period), 0x1C (high period), 0x20 (run modes), 0x24 (global control) and 0x28 (compare, by default). A read returns the register value held just before the clock edge that captures the address.
- R3: A half counts by one per cycle only while global control bits 3:2 equal 01 and its release bit (bit 0 for low, bit 1 for high) is 1. While its release bit is 0, its counter is forced to 0.
- R4: In repeating mode (field value 10), a counter equal to its period returns to 0 on the next edge, and that half's interrupt is high for the following cycle. A period of 0xFFFFFFFF wraps across the full 32-bit range.
- R5: In single-shot mode (field value 01), the period match raises one interrupt pulse. The counter returns to 0, the hardware clears that half's field to 00, and counting stops.
- R6: The run-mode field of the low half is bits 7:6 of the 0x20 word and that of the high half is bits 23:22. Values 00 and 11 hold the count still. Rewriting the word with one field changed leaves the other half's count and mode undisturbed.
- R7: With the compare register present, the low-half interrupt also pulses in the cycle after a running low count equals the compare value, and the low half keeps counting.
- R8: Reserved bits read as 0. Undefined offsets read as 0, and writes to them change no register.
- R9: A software write to a counter takes effect on the edge it is presented and overrides that edge's increment. A software write of the 0x20 word overrides a same-edge single-shot clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | AW (8) | Byte offset of the register |
| reg_wdata | input | W (32) | Write data |
| reg_rdata | output | W (32) | Registered read data for the previous cycle's address |
| irq_lo | output | 1 | Low-half interrupt pulse |
| irq_hi | output | 1 | High-half interrupt pulse |

## Verification
The hardest case to reach from the ports is a single-shot expiry that lands on the same edge as a write of the run-mode word, or of that half's counter. The priority between hardware and software then decides the result. The random stimulus uses periods and counter preloads of only a few dozen cycles and writes on about a quarter of all cycles, so such collisions occur many times. A cycle-level reference model in the bench judges every one of them. The full-range wrap cannot be reached by counting from zero, so directed steps preload a counter a few counts below 0xFFFFFFFF.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;
  localparam int NHALF = 2;

  // run-mode field values
  localparam logic [1:0] RM_STOP = 2'b00;
  localparam logic [1:0] RM_ONCE = 2'b01;
  localparam logic [1:0] RM_LOOP = 2'b10;

  // global arrangement value for two independent halves
  localparam logic [1:0] GA_SPLIT = 2'b01;

  // register byte offsets
  localparam int OFS_CNT0 = 'h10;
  localparam int OFS_PRD0 = 'h18;
  localparam int OFS_RUN  = 'h20;
  localparam int OFS_GLB  = 'h24;

  // run-mode field positions inside the 0x20 word
  localparam int RM_LSB_LO = 6;
  localparam int RM_LSB_HI = 22;
endpackage

// File: rtl/dtmr_half.sv
`timescale 1ns/1ps
module dtmr_half
  import dtmr_pkg::*;
#(
  parameter int W       = 32,
  parameter bit HAS_CMP = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         live,
  input  logic         cnt_we,
  input  logic         prd_we,
  input  logic         mode_we,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   mode_wdata,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] prd,
  output logic [1:0]   mode,
  output logic         irq
);
  logic run;
  logic at_prd;
  logic hit_cmp;

  assign run    = go && live && ((mode == RM_ONCE) || (mode == RM_LOOP));
  assign at_prd = (cnt == prd);

  generate
    if (HAS_CMP) begin : g_cmp
      assign hit_cmp = (cnt == cmp_val);
    end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = ^cmp_val;
      assign hit_cmp    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      prd  <= '1;
      mode <= RM_STOP;
      irq  <= 1'b0;
    end else begin
      irq <= run && (at_prd || hit_cmp);

      if (prd_we) prd <= wdata;

      if (!live)       cnt <= '0;
      else if (cnt_we) cnt <= wdata;
      else if (run)    cnt <= at_prd ? '0 : cnt + 1'b1;

      if (mode_we)                                 mode <= mode_wdata;
      else if (run && (mode == RM_ONCE) && at_prd) mode <= RM_STOP;
    end
  end
endmodule

// File: rtl/dtmr_rdmux.sv
`timescale 1ns/1ps
module dtmr_rdmux
  import dtmr_pkg::*;
#(
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter bit CMP_EN  = 1'b1,
  parameter int CMP_OFS = 'h28
) (
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  cnt0,
  input  logic [W-1:0]  cnt1,
  input  logic [W-1:0]  prd0,
  input  logic [W-1:0]  prd1,
  input  logic [1:0]    rm0,
  input  logic [1:0]    rm1,
  input  logic [3:0]    glb,
  input  logic [W-1:0]  cmp,
  output logic [W-1:0]  rd
);
  always_comb begin
    rd = '0;
    if (addr == AW'(OFS_CNT0))          rd = cnt0;
    else if (addr == AW'(OFS_CNT0 + 4)) rd = cnt1;
    else if (addr == AW'(OFS_PRD0))     rd = prd0;
    else if (addr == AW'(OFS_PRD0 + 4)) rd = prd1;
    else if (addr == AW'(OFS_RUN)) begin
      rd[RM_LSB_LO +: 2] = rm0;
      rd[RM_LSB_HI +: 2] = rm1;
    end
    else if (addr == AW'(OFS_GLB))      rd[3:0] = glb;
    else if (CMP_EN && (addr == AW'(CMP_OFS))) rd = cmp;
  end
endmodule

// File: rtl/dual_timer32.sv
`timescale 1ns/1ps
module dual_timer32
  import dtmr_pkg::*;
#(
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter bit CMP_EN  = 1'b1,
  parameter int CMP_OFS = 'h28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          irq_lo,
  output logic          irq_hi
);
  logic [3:0]       glb_q;
  logic [W-1:0]     cmp_q;
  logic [W-1:0]     cnt_q [NHALF];
  logic [W-1:0]     prd_q [NHALF];
  logic [1:0]       rm_q  [NHALF];
  logic [NHALF-1:0] irq_q;
  logic [NHALF-1:0] cnt_we;
  logic             run_we;
  logic             glb_we;
  logic             go;
  logic [W-1:0]     rd_next;

  assign run_we = reg_we && (reg_addr == AW'(OFS_RUN));
  assign glb_we = reg_we && (reg_addr == AW'(OFS_GLB));
  assign go     = (glb_q[3:2] == GA_SPLIT);

  always_ff @(posedge clk) begin
    if (rst)         glb_q <= '0;
    else if (glb_we) glb_q <= reg_wdata[3:0];
  end

  generate
    if (CMP_EN) begin : g_cmpreg
      always_ff @(posedge clk) begin
        if (rst) cmp_q <= '1;
        else if (reg_we && (reg_addr == AW'(CMP_OFS))) cmp_q <= reg_wdata;
      end
    end else begin : g_nocmpreg
      assign cmp_q = '1;
    end
  endgenerate

  generate
    for (genvar h = 0; h < NHALF; h++) begin : g_half
      localparam int LSB = (h == 0) ? RM_LSB_LO : RM_LSB_HI;
      assign cnt_we[h] = reg_we && (reg_addr == AW'(OFS_CNT0 + 4*h));
      dtmr_half #(.W(W), .HAS_CMP((h == 0) && CMP_EN)) u_half (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .live       (glb_q[h]),
        .cnt_we     (cnt_we[h]),
        .prd_we     (reg_we && (reg_addr == AW'(OFS_PRD0 + 4*h))),
        .mode_we    (run_we),
        .wdata      (reg_wdata),
        .mode_wdata (reg_wdata[LSB +: 2]),
        .cmp_val    (cmp_q),
        .cnt        (cnt_q[h]),
        .prd        (prd_q[h]),
        .mode       (rm_q[h]),
        .irq        (irq_q[h])
      );
    end
  endgenerate

  dtmr_rdmux #(.W(W), .AW(AW), .CMP_EN(CMP_EN), .CMP_OFS(CMP_OFS)) u_rdmux (
    .addr (reg_addr),
    .cnt0 (cnt_q[0]),
    .cnt1 (cnt_q[1]),
    .prd0 (prd_q[0]),
    .prd1 (prd_q[1]),
    .rm0  (rm_q[0]),
    .rm1  (rm_q[1]),
    .glb  (glb_q),
    .cmp  (cmp_q),
    .rd   (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign irq_lo = irq_q[0];
  assign irq_hi = irq_q[1];
endmodule

// File: rtl/dtmr_chk.sv
`timescale 1ns/1ps
module dtmr_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   glb,
  input logic [1:0]   rm_lo,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] prd_lo,
  input logic [W-1:0] cmp,
  input logic         irq_lo,
  input logic         cnt_we_lo,
  input logic         run_we
);
  logic run_lo;
  assign run_lo = (glb[3:2] == 2'b01) && glb[0] && ((rm_lo == 2'b01) || (rm_lo == 2'b10));

  // R3: a held half sits at zero
  a_r3_held_zero: assert property (@(posedge clk) disable iff (rst)
    !glb[0] |=> (cnt_lo == '0));

  // R3: a running half advances by one
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (run_lo && (cnt_lo != prd_lo) && !cnt_we_lo) |=> (cnt_lo == $past(cnt_lo) + 1'b1));

  // R4: period match returns the count to zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (run_lo && (cnt_lo == prd_lo) && !cnt_we_lo) |=> (cnt_lo == '0));

  // R4, R7: every interrupt has a period or compare cause
  a_r4_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(run_lo && ((cnt_lo == prd_lo) || (cnt_lo == cmp))));

  // R5: single-shot expiry clears the field
  a_r5_once_clear: assert property (@(posedge clk) disable iff (rst)
    (run_lo && (rm_lo == 2'b01) && (cnt_lo == prd_lo) && !run_we) |=> (rm_lo == 2'b00));

  // R6: a released but idle half keeps its count
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (glb[0] && !run_lo && !cnt_we_lo) |=> $stable(cnt_lo));
endmodule

bind dual_timer32 dtmr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .glb       (glb_q),
  .rm_lo     (rm_q[0]),
  .cnt_lo    (cnt_q[0]),
  .prd_lo    (prd_q[0]),
  .cmp       (cmp_q),
  .irq_lo    (irq_lo),
  .cnt_we_lo (cnt_we[0]),
  .run_we    (run_we)
);

// File: tb/tb_dual_timer32.sv
`timescale 1ns/1ps
module tb_dual_timer32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pulses_lo = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_timer32 dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // reference model built from the requirements
  logic [31:0] m_cnt [2];
  logic [31:0] m_prd [2];
  logic [1:0]  m_rm  [2];
  logic        m_irq [2];
  logic [3:0]  m_glb;
  logic [31:0] m_cmp;
  logic [31:0] m_rd;

  function automatic logic [31:0] f_read(input logic [7:0] a);
    logic [31:0] v;
    v = 32'h0;
    case (a)
      8'h10: v = m_cnt[0];
      8'h14: v = m_cnt[1];
      8'h18: v = m_prd[0];
      8'h1C: v = m_prd[1];
      8'h20: begin v[7:6] = m_rm[0]; v[23:22] = m_rm[1]; end
      8'h24: v[3:0] = m_glb;
      8'h28: v = m_cmp;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int h = 0; h < 2; h++) begin
        m_cnt[h] <= 32'h0; m_prd[h] <= 32'hFFFF_FFFF; m_rm[h] <= 2'b00; m_irq[h] <= 1'b0;
      end
      m_glb <= 4'h0; m_cmp <= 32'hFFFF_FFFF; m_rd <= 32'h0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        logic live, run, atp, cmph;
        live = m_glb[h];
        run  = (m_glb[3:2] == 2'b01) && live && (m_rm[h] == 2'b01 || m_rm[h] == 2'b10);
        atp  = (m_cnt[h] == m_prd[h]);
        cmph = (h == 0) && (m_cnt[0] == m_cmp);
        m_irq[h] <= run && (atp || cmph);
        if (!live) m_cnt[h] <= 32'h0;
        else if (reg_we && reg_addr == 8'(8'h10 + 4*h)) m_cnt[h] <= reg_wdata;
        else if (run) m_cnt[h] <= atp ? 32'h0 : m_cnt[h] + 32'h1;
        if (reg_we && reg_addr == 8'(8'h18 + 4*h)) m_prd[h] <= reg_wdata;
        if (reg_we && reg_addr == 8'h20) m_rm[h] <= (h == 0) ? reg_wdata[7:6] : reg_wdata[23:22];
        else if (run && m_rm[h] == 2'b01 && atp) m_rm[h] <= 2'b00;
      end
      if (reg_we && reg_addr == 8'h24) m_glb <= reg_wdata[3:0];
      if (reg_we && reg_addr == 8'h28) m_cmp <= reg_wdata;
      m_rd <= f_read(reg_addr);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(reg_rdata == m_rd, "R2 read data vs model", reg_rdata, m_rd);
      chk(irq_lo == m_irq[0], "R4 irq_lo vs model", {31'h0, irq_lo}, {31'h0, m_irq[0]});
      chk(irq_hi == m_irq[1], "R4 irq_hi vs model", {31'h0, irq_hi}, {31'h0, m_irq[1]});
      if (irq_lo) pulses_lo++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq_lo();
    for (int i = 0; i < 300 && !irq_lo; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int c1, c2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h10, v); chk(v == 32'h0, "R1 low count", v, 32'h0);
    rd(8'h14, v); chk(v == 32'h0, "R1 high count", v, 32'h0);
    rd(8'h18, v); chk(v == 32'hFFFF_FFFF, "R1 low period", v, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk(v == 32'hFFFF_FFFF, "R1 high period", v, 32'hFFFF_FFFF);
    rd(8'h20, v); chk(v == 32'h0, "R1 run modes", v, 32'h0);
    rd(8'h24, v); chk(v == 32'h0, "R1 global", v, 32'h0);
    rd(8'h28, v); chk(v == 32'hFFFF_FFFF, "R1 compare", v, 32'hFFFF_FFFF);
    chk(!irq_lo && !irq_hi, "R1 irqs low", {30'h0, irq_hi, irq_lo}, 32'h0);

    // R3 release bits and arrangement field
    wr(8'h20, 32'h0080_0080);
    wr(8'h24, 32'h6);
    repeat (10) @(negedge clk);
    rd(8'h10, v); chk(v == 32'h0, "R3 held low half at zero", v, 32'h0);
    rd(8'h14, v); c1 = cyc;
    repeat (7) @(negedge clk);
    rd(8'h14, v2); c2 = cyc;
    chk(v2 - v == 32'(c2 - c1), "R3 released high half counts", v2 - v, 32'(c2 - c1));
    wr(8'h24, 32'hB);
    rd(8'h14, v);
    repeat (6) @(negedge clk);
    rd(8'h14, v2);
    chk(v2 == v, "R3 arrangement not 01 holds count", v2, v);
    wr(8'h24, 32'h7);

    // R9 counter write takes effect
    wr(8'h14, 32'd1000); c1 = cyc;
    rd(8'h14, v); c2 = cyc;
    chk(v == 32'd1000 + 32'(c2 - c1 - 1), "R9 counter write overrides count", v, 32'd1000 + 32'(c2 - c1 - 1));

    // R4 repeating period gap
    wr(8'h18, 32'd4);
    wr(8'h10, 32'd0);
    wait_irq_lo(); c1 = cyc;
    @(negedge clk);
    wait_irq_lo(); c2 = cyc;
    chk(c2 - c1 == 5, "R4 period 4 pulse spacing", 32'(c2 - c1), 32'd5);

    // R4 full-range wrap
    wr(8'h14, 32'hFFFF_FFFE); c1 = cyc;
    repeat (4) @(negedge clk);
    rd(8'h14, v); c2 = cyc;
    chk(v == 32'hFFFF_FFFE + 32'(c2 - c1 - 1), "R4 full-range wrap", v, 32'hFFFF_FFFE + 32'(c2 - c1 - 1));

    // R5 single shot
    wr(8'h24, 32'h6);
    wr(8'h18, 32'd6);
    wr(8'h20, 32'h0080_0040);
    pulses_lo = 0;
    wr(8'h24, 32'h7);
    repeat (40) @(negedge clk);
    chk(pulses_lo == 1, "R5 single pulse", 32'(pulses_lo), 32'd1);
    rd(8'h20, v); chk(v == 32'h0080_0000, "R5 field cleared", v, 32'h0080_0000);
    rd(8'h10, v); repeat (3) @(negedge clk); rd(8'h10, v2);
    chk(v == 32'h0 && v2 == 32'h0, "R5 count stopped at zero", v2, 32'h0);

    // R6 other half undisturbed, value 11 holds
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h14, v); c1 = cyc;
    wr(8'h20, 32'h0080_0080);
    wr(8'h20, 32'h0080_0000);
    wr(8'h20, 32'h0080_0040);
    rd(8'h14, v2); c2 = cyc;
    chk(v2 - v == 32'(c2 - c1), "R6 high half undisturbed", v2 - v, 32'(c2 - c1));
    wr(8'h10, 32'd9);
    wr(8'h20, 32'h0080_00C0);
    rd(8'h10, v); repeat (4) @(negedge clk); rd(8'h10, v2);
    chk(v2 == v, "R6 field value 11 holds count", v2, v);

    // R7 compare event
    wr(8'h24, 32'h6);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'd20);
    wr(8'h20, 32'h0080_0080);
    wr(8'h24, 32'h7);
    wait_irq_lo();
    rd(8'h10, v);
    chk(v == 32'd21, "R7 compare pulse and continued count", v, 32'd21);

    // R8 reserved bits and undefined offsets
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40, v); chk(v == 32'h0, "R8 undefined offset reads zero", v, 32'h0);
    rd(8'h18, v); chk(v == 32'hFFFF_FFFF, "R8 undefined write left period", v, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk(v == 32'h00C0_00C0, "R8 run word reserved bits", v, 32'h00C0_00C0);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, v); chk(v == 32'hF, "R8 global reserved bits", v, 32'hF);
    rd(8'h2C, v); chk(v == 32'h0, "R8 gap offset reads zero", v, 32'h0);

    // random phase, judged by the model (R2 R4 R5 R9)
    wr(8'h24, 32'h7);
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      case ($urandom % 9)
        0: a = 8'h10; 1: a = 8'h14; 2: a = 8'h18; 3: a = 8'h1C; 4: a = 8'h20;
        5: a = 8'h24; 6: a = 8'h28; 7: a = 8'h40; default: a = 8'h2C;
      endcase
      case (a)
        8'h10, 8'h14, 8'h28: d = $urandom % 30;
        8'h18, 8'h1C: d = $urandom % 25;
        8'h20: d = ($urandom & 32'hFF3F_FF3F) | (32'($urandom % 4) << 6) | (32'($urandom % 4) << 22);
        8'h24: d = (($urandom % 5) == 0) ? 32'($urandom % 16) : 32'h7;
        default: d = $urandom;
      endcase
      if (($urandom % 4) == 0) wr(a, d);
      else begin reg_addr = a; @(negedge clk); end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule